// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

A parameterised general-purpose I/O port on a plain word-addressed register bus (address, write enable, write data, read enable, read data). Software controls each line through an output latch and a direction bit. The latch can be loaded as a whole word, or individual lines can be driven high or low with atomic write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. Direction is held in one register that is reachable under two names: one where a 1 marks an output, and one where a 1 marks an input. The second always reads as the complement of the first, so a line is never input and output at once.

Each line drives a tri-state pad through an output value and an output enable. The pad level comes back through a two-flop synchroniser and is what a data-register read returns. Build-time parameters choose the register width (8, 16, 32 or 64), a line count no larger than that width, a mirrored line-to-bit order, and whether the set register reads back the output latch.

Top module: `gpio_mmio_port`

## Requirements
- R1: While rst_ni is low and after its release, before any write, every pad_oe_o and pad_out_o bit is 0 and rdata_o is 0.
- R2: A write to offset 1 (set) drives a 1 on every line whose mapped bit in wdata_i is 1 and leaves the other lines unchanged.
- R3: A write to offset 2 (clear) drives a 0 on every line whose mapped bit in wdata_i is 1 and leaves the other lines unchanged; reads of offset 2 return 0.
- R4: A write to offset 0 (data) loads the whole output latch; a read of offset 0 returns the synchronised pad input levels.
- R5: A change on pad_in_i is not seen by a data read loaded at the second rising edge after the change and is seen by one loaded at the third.
- R6: A write to offset 3 (output direction) sets pad_oe_o: a 1 bit makes that line an output. Reading offset 3 returns the direction word.
- R7: A write to offset 4 (input direction) makes lines whose bit is 1 inputs and the others outputs. A read of offset 4 always returns the bitwise inverse, across the full register width, of a read of offset 3.
- R8: With MIRROR=0 line n uses register bit n; with MIRROR=1 it uses bit REG_W-1-n. Register bits with no line read 0 at offsets 0, 1 and 3 and a write to them changes no pad.
- R9: With SET_READS_LATCH=1 a read of offset 1 returns the output latch in register bit order; with SET_READS_LATCH=0 it returns 0.
- R10: Writes to offsets 5 to 7 change no pad output or enable; reads from them return 0.
- R11: rdata_o is loaded at the rising edge where re_i is high, one cycle after the strobe, and holds while re_i is low; pad_out_o and pad_oe_o change at the rising edge of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word offset of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | REG_W | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | REG_W | Registered read data |
| pad_out_o | output | N_LINES | Output value per line |
| pad_oe_o | output | N_LINES | Output enable per line, 1 drives the pad |
| pad_in_i | input | N_LINES | Asynchronous pad level per line |

## Verification
The bench runs a full-width unmirrored port and a 12-line, 16-bit mirrored port with set read-back disabled side by side, looping each pad output back through its enable. It aims at the set and clear words touching only their marked lines (a design that wrote the word as data would wipe the other lines), at the input-direction alias reading as the exact complement including lines that do not exist, and at mirrored mapping where a reversed index would drive the wrong pad. It also times the synchroniser edge by edge, so a design with one flop too many or too few returns the new level one read early or late, and it writes and reads the unused offsets, where a partial decode would alias onto a real register.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_SET  = 3'd1;
  localparam logic [2:0] OFF_CLR  = 3'd2;
  localparam logic [2:0] OFF_DOUT = 3'd3;
  localparam logic [2:0] OFF_DIN  = 3'd4;

  typedef struct packed {
    logic dat;
    logic set;
    logic clr;
    logic dout;
    logic din;
  } gpio_sel_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mmio_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_sel_t         sel_o
);
  always_comb begin
    sel_o = '0;
    if (addr_i <= ADDR_W'(OFF_DIN)) begin
      unique case (addr_i[2:0])
        OFF_DATA: sel_o.dat  = 1'b1;
        OFF_SET:  sel_o.set  = 1'b1;
        OFF_CLR:  sel_o.clr  = 1'b1;
        OFF_DOUT: sel_o.dout = 1'b1;
        default:  sel_o.din  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/gpio_w2l.sv
// Register word to per-line vector.
module gpio_w2l #(
  parameter int REG_W   = 32,
  parameter int N_LINES = REG_W,
  parameter bit MIRROR  = 1'b0
) (
  input  logic [REG_W-1:0]   word_i,
  output logic [N_LINES-1:0] line_o
);
  for (genvar n = 0; n < N_LINES; n++) begin : g_ln
    localparam int B = MIRROR ? (REG_W - 1 - n) : n;
    assign line_o[n] = word_i[B];
  end
endmodule

// File: rtl/gpio_l2w.sv
// Per-line vector to register word; bits without a line read 0.
module gpio_l2w #(
  parameter int REG_W   = 32,
  parameter int N_LINES = REG_W,
  parameter bit MIRROR  = 1'b0
) (
  input  logic [N_LINES-1:0] line_i,
  output logic [REG_W-1:0]   word_o
);
  always_comb begin
    word_o = '0;
    for (int n = 0; n < N_LINES; n++) begin
      if (MIRROR) word_o[REG_W-1-n] = line_i[n];
      else        word_o[n]         = line_i[n];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_mmio_pkg::*;
#(
  parameter int REG_W           = 32,
  parameter int N_LINES         = REG_W,
  parameter bit MIRROR          = 1'b0,
  parameter bit SET_READS_LATCH = 1'b1,
  parameter int ADDR_W          = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               re_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [N_LINES-1:0] pad_out_o,
  output logic [N_LINES-1:0] pad_oe_o,
  input  logic [N_LINES-1:0] pad_in_i
);
  localparam bit WIDTH_OK = (REG_W == 8) || (REG_W == 16) ||
                            (REG_W == 32) || (REG_W == 64);
  localparam bit CFG_OK   = WIDTH_OK && (N_LINES >= 1) &&
                            (N_LINES <= REG_W) && (ADDR_W >= 3);

  if (!CFG_OK) begin : g_bad_cfg
    $error("gpio_mmio_port: unsupported REG_W/N_LINES/ADDR_W");
  end

  gpio_sel_t          sel;
  logic [N_LINES-1:0] wr_lines, out_q, dir_q, pin_s;
  logic [REG_W-1:0]   out_word, dir_word, pin_word, rd_mux, rdata_q;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpio_w2l #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_wmap (
    .word_i (wdata_i),
    .line_o (wr_lines)
  );

  gpio_l2w #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_out_map (
    .line_i (out_q),
    .word_o (out_word)
  );

  gpio_l2w #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_dir_map (
    .line_i (dir_q),
    .word_o (dir_word)
  );

  gpio_l2w #(.REG_W(REG_W), .N_LINES(N_LINES), .MIRROR(MIRROR)) u_pin_map (
    .line_i (pin_s),
    .word_o (pin_word)
  );

  gpio_in_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  // Reset: all lines input, latch low.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (we_i) begin
      if (sel.dat)  out_q <= wr_lines;
      if (sel.set)  out_q <= out_q | wr_lines;
      if (sel.clr)  out_q <= out_q & ~wr_lines;
      if (sel.dout) dir_q <= wr_lines;
      if (sel.din)  dir_q <= ~wr_lines;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.dat)                    rd_mux = pin_word;
    if (sel.set && SET_READS_LATCH) rd_mux = out_word;
    if (sel.dout)                   rd_mux = dir_word;
    if (sel.din)                    rd_mux = ~dir_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/gpio_mmio_chk.sv
module gpio_mmio_chk #(
  parameter int REG_W           = 32,
  parameter int N_LINES         = REG_W,
  parameter bit SET_READS_LATCH = 1'b1,
  parameter int ADDR_W          = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic               re_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic [N_LINES-1:0] pad_out_o,
  input logic [N_LINES-1:0] pad_oe_o
);
  p_set_keeps_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1)) |=>
      ((pad_out_o & $past(pad_out_o)) == $past(pad_out_o)));

  p_clr_adds_no_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(2)) |=> ((pad_out_o & ~$past(pad_out_o)) == '0));

  p_clr_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(2)) |=> (rdata_o == '0));

  p_set_rd_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(1) && !SET_READS_LATCH) |=> (rdata_o == '0));

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i <= ADDR_W'(2)) |=> $stable(pad_out_o));

  p_oe_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == ADDR_W'(3) || addr_i == ADDR_W'(4))) |=> $stable(pad_oe_o));

  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i > ADDR_W'(4)) |=> (rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind gpio_mmio_port gpio_mmio_chk #(
  .REG_W(REG_W), .N_LINES(N_LINES), .SET_READS_LATCH(SET_READS_LATCH), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
  .rdata_o(rdata_o), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
);

// File: tb/sim_gpio_mmio_port.sv
`timescale 1ns/1ps
module sim_gpio_mmio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, ext0 = '0, out0, oe0, pin0;
  logic [15:0] rdata1;
  logic [11:0] out1, oe1, pin1, ext1 = '0;
  logic [31:0] rd0;
  logic [15:0] rd1;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  assign pin0 = (out0 & oe0) | (ext0 & ~oe0);
  assign pin1 = (out1 & oe1) | (ext1 & ~oe1);

  gpio_mmio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata0), .pad_out_o(out0), .pad_oe_o(oe0), .pad_in_i(pin0)
  );

  gpio_mmio_port #(.REG_W(16), .N_LINES(12), .MIRROR(1'b1), .SET_READS_LATCH(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata[15:0]),
    .re_i(re), .rdata_o(rdata1), .pad_out_o(out1), .pad_oe_o(oe1), .pad_in_i(pin1)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    rd0 = rdata0; rd1 = rdata1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oe0", oe0, 0);  chk("R1 out0", out0, 0); chk("R1 rdata0", rdata0, 0);
    chk("R1 oe1", oe1, 0);  chk("R1 out1", out1, 0);
  endtask

  task automatic t_set_clear;
    bus_wr(3'd1, 32'h0000_00F0); chk("R2 set", out0, 32'hF0);
    bus_wr(3'd1, 32'h0000_000F); chk("R2 set keeps", out0, 32'hFF);
    bus_wr(3'd2, 32'h0000_003C); chk("R3 clear", out0, 32'hC3);
    bus_rd(3'd2);                chk("R3 clear reads 0", rd0, 0);
    bus_rd(3'd1);                chk("R9 set reads latch", rd0, 32'hC3);
  endtask

  task automatic t_data_dir;
    bus_wr(3'd0, 32'hA5A5_0000); chk("R4 data load", out0, 32'hA5A5_0000);
    bus_wr(3'd3, 32'hFFFF_0000); chk("R6 oe", oe0, 32'hFFFF_0000);
    bus_rd(3'd3);                chk("R6 dirout rd", rd0, 32'hFFFF_0000);
    bus_rd(3'd4);                chk("R7 dirin rd", rd0, 32'h0000_FFFF);
    bus_wr(3'd4, 32'hF000_FFFF); chk("R7 dirin wr", oe0, 32'h0FFF_0000);
    bus_rd(3'd3);                chk("R7 dirout after dirin", rd0, 32'h0FFF_0000);
    ext0 = 32'h0000_1234;
    idle(3);
    bus_rd(3'd0);                chk("R4 data reads pins", rd0, 32'h05A5_1234);
  endtask

  task automatic t_sync;
    ext0 = 32'h0000_4321;
    bus_rd(3'd0);
    bus_rd(3'd0);                chk("R5 edge2 old", rd0, 32'h05A5_1234);
    bus_rd(3'd0);                chk("R5 edge3 new", rd0, 32'h05A5_4321);
  endtask

  task automatic t_unmapped;
    bus_wr(3'd5, 32'hFFFF_FFFF);
    bus_wr(3'd6, 32'h0000_0000);
    bus_wr(3'd7, 32'hFFFF_FFFF);
    chk("R10 out kept", out0, 32'hA5A5_0000);
    chk("R10 oe kept", oe0, 32'h0FFF_0000);
    bus_rd(3'd5);                chk("R10 rd5", rd0, 0);
    bus_rd(3'd7);                chk("R10 rd7", rd0, 0);
  endtask

  task automatic t_hold;
    bus_rd(3'd3);
    idle(4);
    chk("R11 rdata holds", rdata0, 32'h0FFF_0000);
    addr = 3'd1; wdata = 32'h1; we = 1'b1;
    @(posedge clk); #1;
    chk("R11 out at write edge", out0, 32'hA5A5_0001);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_mirror;
    bus_wr(3'd0, 32'h0000_FFFF); chk("R8 mirror 12 lines", out1, 12'hFFF);
    bus_wr(3'd2, 32'h0000_4000); chk("R8 mirror clear line1", out1, 12'hFFD);
    bus_wr(3'd1, 32'h0000_000F); chk("R8 unmapped bits no effect", out1, 12'hFFD);
    bus_wr(3'd3, 32'h0000_8000); chk("R8 mirror oe line0", oe1, 12'h001);
    bus_rd(3'd3);                chk("R8 dirout rd mirrored", rd1, 16'h8000);
    bus_rd(3'd4);                chk("R7 dirin full inverse", rd1, 16'h7FFF);
    bus_rd(3'd1);                chk("R9 set reads 0", rd1, 16'h0000);
    idle(3);
    bus_rd(3'd0);                chk("R8 data rd mirrored", rd1, 16'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_set_clear;
    t_data_dir;
    t_sync;
    t_unmapped;
    t_hold;
    t_mirror;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule